// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets logic clocked by a system clock use an asynchronous 64K x 16 static RAM. Each access is one request. The request carries a read/write flag, a 16-bit word address, 16 bits of write data and two byte-enable bits. The block drives the RAM's active-low strobes, its address and its data. It completes the access and pulses `done` for one cycle. For a read, the captured word appears on `rd_data`.

Every timing minimum of the RAM is given in nanoseconds as a parameter. The clock period is also a parameter. The block turns each time into a cycle count, rounding up. A nonzero time always gets at least one cycle. The data pins are split into an output word, an input word and a drive-enable bit, so the tristate buffer sits outside the block.

Reads are gated by output enable. Writes are gated by write enable and use the byte selects. Chip enable goes high between any two accesses, which covers every change between read and write. The address only moves while write enable is high.

With the default parameters the counts are as follows:

| Time | Nanoseconds | Cycles |
|---|---|---|
| Clock period | 8 | 1 |
| Read cycle | 150 | 19 |
| Output enable to data | 80 | 10 |
| Write cycle | 150 | 19 |
| Write pulse | 80 | 10 |
| Data setup | 40 | 5 |
| Byte select to end of write | 70 | 9 |
| Bus turnaround | 40 | 5 |

Top module: `sram_seq_ctrl`

## Requirements
- R1: In the cycle after reset is applied, all of the following hold: `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are 1, `mem_dq_oe` is 0, `done` is 0, `req_ready` is 1 and `rd_data` is 0.
- R2: A request is accepted only on a clock edge where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the block is idle. `req_ready` is low in the cycle after acceptance. `done` is high for exactly one cycle per access, in the cycle after the access ends.
- R3: For a read, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` is high for exactly N_RD = ceil(max(T_RC, T_OE) / T_CLK) cycles (19 with the defaults). `req_be[0]` controls `mem_lb_n` and byte bits 7:0. `req_be[1]` controls `mem_ub_n` and bits 15:8. A lane select is driven low exactly when its enable bit is 1. At the end of the last cycle, the enabled lanes of `mem_dq_in` are captured into `rd_data`, and disabled lanes read as zero.
- R4: `rd_data` changes only when a read completes. Writes leave it unchanged.
- R5: For a write, `mem_we_n` stays low for exactly N_WL = max(ceil(T_WP), ceil(T_DW), ceil(T_BW), ceil(T_WC) - N_TURN, 1) cycles (14 with the defaults). For that whole window, `mem_dq_out` equals the request data and `mem_dq_oe` is 1. Only the lanes enabled in `req_be` have their select low. A disabled lane keeps its previous memory contents.
- R6: `mem_dq_oe` rises only after `mem_oe_n` has been high for at least N_TURN = max(ceil(T_OHZ / T_CLK), 1) cycles (5 with the defaults). `mem_dq_oe` is never high while `mem_oe_n` is low, and `mem_oe_n` and `mem_we_n` are never low together.
- R7: `mem_addr` changes only when `mem_we_n` is high, both in the cycle before the change and in the cycle of the change. The address stays constant while `mem_ce_n` is low.
- R8: `mem_ce_n` goes high for at least one cycle between two consecutive accesses, including back-to-back requests. A write holds `mem_ce_n` low for N_TURN + N_WL + 1 cycles (20 with the defaults), so the time from chip-enable fall to write-enable rise is at least ceil(T_WC / T_CLK).
- R9: Write enable rises one cycle before chip enable, the byte selects and the data drivers are released. The write therefore ends on write enable, with the data held for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read word, held until the next read completes |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_oe | output | 1 | Enable for the data drivers toward the memory |

## Verification
Two events can fall in the same cycle. One is the completion of an access, which brings the `done` pulse and the release of chip enable. The other is the acceptance of the next request, possibly of the opposite kind.

The bench provokes this by raising `req_valid` in the very cycle that shows `done`. It does so for read-after-read, read-after-write and write-after-read pairs on the same and on different addresses. A bus monitor then judges the result. It checks that chip enable still went high for a cycle. It checks the exact low-time of each access and the write-enable pulse width. It checks that the data drivers waited out the turnaround after output enable rose. Finally, the word read back must match a reference image kept by the bench.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_WTURN  = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WREC   = 3'd4
  } seq_state_t;

  // nanoseconds to whole cycles, rounded up; zero stays zero
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns <= 0) ? 0 : (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_lane_merge.sv
module sram_lane_merge #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0]    din,
  output logic [LANES-1:0] sel_n,
  output logic [DW-1:0]    dmask
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel_n[g]                = ~be[g];
    assign dmask[g*LANE_W +: LANE_W] = be[g] ? din[g*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int T_CLK  = 8,
  parameter int T_RC   = 150,
  parameter int T_OE   = 80,
  parameter int T_WC   = 150,
  parameter int T_WP   = 80,
  parameter int T_DW   = 40,
  parameter int T_BW   = 70,
  parameter int T_OHZ  = 40,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_dq_out,
  input  logic [DW-1:0]     mem_dq_in,
  output logic              mem_dq_oe
);
  import sram_ctrl_pkg::*;

  localparam int C_RC   = ns_to_cyc(T_RC, T_CLK);
  localparam int C_OE   = ns_to_cyc(T_OE, T_CLK);
  localparam int C_WC   = ns_to_cyc(T_WC, T_CLK);
  localparam int C_WP   = ns_to_cyc(T_WP, T_CLK);
  localparam int C_DW   = ns_to_cyc(T_DW, T_CLK);
  localparam int C_BW   = ns_to_cyc(T_BW, T_CLK);
  localparam int N_RD   = imax(imax(C_RC, C_OE), 1);
  localparam int N_TURN = imax(ns_to_cyc(T_OHZ, T_CLK), 1);
  localparam int N_WL   = imax(imax(imax(C_WP, C_DW), imax(C_BW, C_WC - N_TURN)), 1);
  localparam int N_MAX  = imax(imax(N_RD, N_TURN), N_WL);
  localparam int CNT_W  = $clog2(N_MAX + 1);

  seq_state_t        state;
  logic [LANES-1:0]  lanes_n;
  logic              t_zero;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic [LANES-1:0]  merge_be;
  logic [LANES-1:0]  merge_sel_n;
  logic [DW-1:0]     merge_data;

  assign req_ready = (state == ST_IDLE);
  assign mem_lb_n  = lanes_n[0];
  assign mem_ub_n  = lanes_n[LANES-1];

  // idle: decode the request enables; read end: mask by the active lanes
  assign merge_be = (state == ST_IDLE) ? req_be : ~lanes_n;

  sram_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .be    (merge_be),
    .din   (mem_dq_in),
    .sel_n (merge_sel_n),
    .dmask (merge_data)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (state == ST_IDLE && req_valid) begin
      t_load = 1'b1;
      t_val  = req_we ? CNT_W'(N_TURN - 1) : CNT_W'(N_RD - 1);
    end else if (state == ST_WTURN && t_zero) begin
      t_load = 1'b1;
      t_val  = CNT_W'(N_WL - 1);
    end
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      lanes_n    <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rd_data    <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            mem_addr   <= req_addr;
            mem_ce_n   <= 1'b0;
            lanes_n    <= merge_sel_n;
            mem_dq_out <= req_wdata;
            if (req_we) begin
              state <= ST_WTURN;
            end else begin
              state    <= ST_RD;
              mem_oe_n <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (t_zero) begin
            rd_data  <= merge_data;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            lanes_n  <= '1;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_WTURN: begin
          if (t_zero) begin
            mem_we_n  <= 1'b0;
            mem_dq_oe <= 1'b1;
            state     <= ST_WPULSE;
          end
        end
        ST_WPULSE: begin
          if (t_zero) begin
            mem_we_n <= 1'b1;
            state    <= ST_WREC;
          end
        end
        ST_WREC: begin
          mem_ce_n  <= 1'b1;
          lanes_n   <= '1;
          mem_dq_oe <= 1'b0;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // checker-side counter of write-enable low time
  logic [CNT_W:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (rst)
      we_low_cnt <= '0;
    else if (!mem_we_n)
      we_low_cnt <= (we_low_cnt == '1) ? we_low_cnt : we_low_cnt + 1'b1;
    else
      we_low_cnt <= '0;
  end

  p_addr_we_high_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  p_drive_safe_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_we_width_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_low_cnt >= (CNT_W+1)'(N_WL)));

  p_we_before_ce_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_ce_n);

endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;

  localparam int CLK_NS = 8;

  function automatic int cyc(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  localparam int E_RD   = (cyc(150) > cyc(80)) ? cyc(150) : cyc(80);
  localparam int E_TURN = cyc(40);
  localparam int E_WL   = 14;              // max(10,5,9,19-5)
  localparam int E_WCE  = E_TURN + E_WL + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        done;
  logic [15:0] rd_data;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_dq_oe;

  always #4 clk = ~clk;

  sram_seq_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .done(done), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model (indexed by low address byte) and bench reference image
  logic [15:0] mem_arr [256];
  logic [15:0] ref_arr [256];
  logic [15:0] cur_addr;

  always_comb begin
    mem_dq_in = 16'hA5A5;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_lb_n) mem_dq_in[7:0]  = mem_arr[mem_addr[7:0]][7:0];
      if (!mem_ub_n) mem_dq_in[15:8] = mem_arr[mem_addr[7:0]][15:8];
    end
  end

  // bus monitor, sampled away from the active edge
  logic        p_ce = 1, p_we = 1, p_oe = 1, p_lb = 1, p_ub = 1, p_dqo = 0, p_done = 0;
  logic [15:0] p_addr = 0, p_dout = 0;
  int ce_run = 0, we_run = 0, oe_hi = 0;
  bit run_read = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_ce_n) begin
        ce_run++;
        if (!mem_oe_n) run_read = 1;
      end
      if (!mem_we_n) we_run++;
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      if (mem_ce_n && !p_ce) begin
        if (run_read) chk(ce_run == E_RD, "R3 read CE low cycles", ce_run, E_RD);
        else          chk(ce_run == E_WCE, "R8 write CE low cycles", ce_run, E_WCE);
        ce_run = 0; run_read = 0;
      end
      if (mem_we_n && !p_we) begin
        chk(we_run == E_WL, "R5 WE low cycles", we_run, E_WL);
        chk(!mem_ce_n, "R9 WE ends write before CE", mem_ce_n, 0);
        chk(p_dqo && p_addr == cur_addr, "R5 write addr/drive", p_addr, cur_addr);
        if (!p_lb) mem_arr[p_addr[7:0]][7:0]  = p_dout[7:0];
        if (!p_ub) mem_arr[p_addr[7:0]][15:8] = p_dout[15:8];
        we_run = 0;
      end
      if (mem_dq_oe && !p_dqo)
        chk(oe_hi >= E_TURN, "R6 turnaround before drive", oe_hi, E_TURN);
      if (mem_dq_oe && !mem_oe_n) chk(0, "R6 drive while OE low", 1, 0);
      if (!mem_we_n && mem_dq_out != p_dout && !p_we)
        chk(0, "R5 data moved during WE low", mem_dq_out, p_dout);
      if (mem_addr != p_addr && (!mem_we_n || !p_we || !p_ce))
        chk(0, "R7 address change", mem_addr, p_addr);
      if (done && p_done) chk(0, "R2 done longer than one cycle", 1, 0);
      if (ce_run > E_WCE) chk(0, "R8 CE never toggled", ce_run, E_WCE);
    end
    p_ce = mem_ce_n; p_we = mem_we_n; p_oe = mem_oe_n; p_lb = mem_lb_n; p_ub = mem_ub_n;
    p_dqo = mem_dq_oe; p_addr = mem_addr; p_dout = mem_dq_out; p_done = done;
  end

  function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] be);
    return {be[1] ? ref_arr[a[7:0]][15:8] : 8'h00, be[0] ? ref_arr[a[7:0]][7:0] : 8'h00};
  endfunction

  logic [15:0] last_rd = 0;

  // issue one access; returns at the negedge showing done
  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    cur_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
    if (we) chk(mem_lb_n == !be[0] && mem_ub_n == !be[1], "R5 lane selects",
                {mem_ub_n, mem_lb_n}, {!be[1], !be[0]});
    else    chk(mem_lb_n == !be[0] && mem_ub_n == !be[1] && !mem_oe_n, "R3 lane selects",
                {mem_ub_n, mem_lb_n}, {!be[1], !be[0]});
    while (!done) @(negedge clk);
    if (we) begin
      if (be[0]) ref_arr[a[7:0]][7:0]  = d[7:0];
      if (be[1]) ref_arr[a[7:0]][15:8] = d[15:8];
      chk(rd_data == last_rd, "R4 rd_data held across write", rd_data, last_rd);
    end else begin
      chk(rd_data == exp_read(a, be), "R3 read data", rd_data, exp_read(a, be));
      last_rd = rd_data;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 16'(i * 16'h0101 ^ 16'h3C5A);
      ref_arr[i] = mem_arr[i];
    end
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1 controls high",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1f);
    chk(!mem_dq_oe && !done && req_ready && rd_data == 0, "R1 idle outputs",
        {mem_dq_oe, done, req_ready}, 3'b001);
    rst = 0;
    @(negedge clk);

    // directed corners
    access(0, 16'h0010, 0, 2'b11);
    access(1, 16'hFFFF, 16'hBEEF, 2'b11);
    access(0, 16'hFFFF, 0, 2'b11);        // write then read, same address
    access(1, 16'h0020, 16'h1234, 2'b01); // lower lane only
    access(1, 16'h0021, 16'h5678, 2'b10); // upper lane only
    access(1, 16'h0022, 16'h9ABC, 2'b00); // no lane
    access(0, 16'h0020, 0, 2'b11);
    access(0, 16'h0021, 0, 2'b01);
    access(0, 16'h0022, 0, 2'b10);
    access(0, 16'h0022, 0, 2'b10);        // back-to-back identical read
    access(0, 16'h0000, 0, 2'b00);

    // random mix
    for (int i = 0; i < 80; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      access(1'($urandom), a, 16'($urandom), 2'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 4)) @(negedge clk);
    end

    repeat (30) @(negedge clk);
    for (int i = 0; i < 256; i++)
      if (mem_arr[i] != ref_arr[i]) chk(0, "R5 memory image", mem_arr[i], ref_arr[i]);
    chk(!done && req_ready, "R2 idle at end", done, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule